// File: doc/BRIEF.md
# Memory Port Write-Readback Tester

This block drives one port of a multi-port memory controller with self-generated traffic and verifies what comes back. Each run begins by drawing a length from a small pseudo-random generator. The block then writes that many words, taking the addresses from one shift-register sequence and the data from another. After the last write it rewinds both generators to the state they held when the run started. It reads the same addresses back in the same order and compares every returned word with the regenerated data. No copy of the written data is kept.

Address width, data width, feedback taps, seeds and counter widths are parameters, so one instance can sit on each port of a controller, whatever the port's size. Several instances running together give the controller a dense mix of concurrent reads and writes. When a run finishes, the next one starts at once from wherever the generators have reached. Results appear as a sticky fail flag, a saturating error count, the address of the first mismatch and a count of completed runs.

Top module: `memport_tester`

## Requirements
- R1: Reset (active-low `rst_n`) puts the block in its write phase with `mem_req` and `mem_we` high. The first address is ADDR_SEED and the first data word is DATA_SEED. `err_cnt`, `run_cnt` and `first_err_addr` are zero and `fail` is low.
- R2: The address generator is a left-shifting register. Its new LSB is the XOR of the current bits selected by ADDR_TAPS. It steps on every accepted write and every accepted read, and an issued address is never zero.
- R3: The data generator works the same way with DATA_TAPS. It steps on every accepted write and on every read word that is checked.
- R4: The run length is the low LEN_W bits of an 8-bit length generator plus one. That generator shifts left, takes taps 0xB8 and starts from LEN_SEED. It steps once per completed run.
- R5: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is high. That cycle completes the transfer.
- R6: The read phase issues the addresses of the run's writes in the same order. After a read is accepted, `mem_req` stays low until `mem_rvalid` delivers the word, so only one read is outstanding.
- R7: Each delivered read word is compared with the regenerated data word. Every mismatch raises `err_cnt` by one, and `err_cnt` saturates at all ones.
- R8: `fail` goes high on the first mismatch and stays high until reset. At the same time `first_err_addr` captures the address of the failing read and then holds.
- R9: When the last word of a run has been checked, `run_cnt` increments and the next write phase starts. It continues from the current generator states, so the write address sequence runs on without a break across runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Transfer request to the controller port |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Transfer address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted in this cycle |
| mem_rdata | input | DW | Read data |
| mem_rvalid | input | 1 | Read data valid |
| fail | output | 1 | Sticky mismatch flag |
| err_cnt | output | ERR_W | Saturating mismatch count |
| first_err_addr | output | AW | Address of the first mismatch |
| run_cnt | output | RUN_W | Completed runs |

## Verification
The assertions check the handshake and counter rules on every cycle:
- the request stays stable until it is accepted;
- issued addresses are never zero;
- only one read is outstanding at a time;
- the error count moves in single steps and stops at its limit;
- the fail flag and first-failure address are sticky;
- each run increment lands on the start of a write.

Only the bench scenarios can show that the generated sequences, the run lengths and the readback order match the generator definitions. They also show that a corrupted word returned by the random-latency memory model is reported with the right address, and that repeated corruption saturates the count.

// File: rtl/memport_tester.sv
module memport_tester #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter logic [AW-1:0] ADDR_TAPS = 10'h240,
  parameter logic [DW-1:0] DATA_TAPS = 16'hD008,
  parameter logic [AW-1:0] ADDR_SEED = 10'h001,
  parameter logic [DW-1:0] DATA_SEED = 16'hACE1,
  parameter int LEN_W = 4,
  parameter logic [7:0] LEN_SEED = 8'h5A,
  parameter int ERR_W = 4,
  parameter int RUN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rvalid,
  output logic             fail,
  output logic [ERR_W-1:0] err_cnt,
  output logic [AW-1:0]    first_err_addr,
  output logic [RUN_W-1:0] run_cnt
);

  localparam logic [7:0]       LEN_TAPS = 8'hB8;
  localparam logic [ERR_W-1:0] ERR_MAX  = {ERR_W{1'b1}};

  typedef enum logic [1:0] {S_WR, S_RD, S_RW} st_t;

  st_t              st;
  logic [AW-1:0]    addr_q, addr_sv, rd_addr;
  logic [DW-1:0]    data_q, data_sv;
  logic [7:0]       len_q;
  logic [LEN_W-1:0] cnt;

  function automatic logic [AW-1:0] step_a(input logic [AW-1:0] s);
    return {s[AW-2:0], ^(s & ADDR_TAPS)};
  endfunction

  function automatic logic [DW-1:0] step_d(input logic [DW-1:0] s);
    return {s[DW-2:0], ^(s & DATA_TAPS)};
  endfunction

  wire hs   = mem_req & mem_ack;
  wire last = (cnt == len_q[LEN_W-1:0]);
  wire chk  = (st == S_RW) & mem_rvalid;
  wire bad  = chk & (mem_rdata != data_q);

  assign mem_req   = (st != S_RW);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_WR;
      addr_q  <= ADDR_SEED;
      addr_sv <= ADDR_SEED;
      data_q  <= DATA_SEED;
      data_sv <= DATA_SEED;
      len_q   <= LEN_SEED;
      cnt     <= '0;
      rd_addr <= '0;
      run_cnt <= '0;
    end else begin
      case (st)
        S_WR: if (hs) begin
          if (last) begin
            addr_q <= addr_sv;
            data_q <= data_sv;
            cnt    <= '0;
            st     <= S_RD;
          end else begin
            addr_q <= step_a(addr_q);
            data_q <= step_d(data_q);
            cnt    <= cnt + 1'b1;
          end
        end
        S_RD: if (hs) begin
          rd_addr <= addr_q;
          addr_q  <= step_a(addr_q);
          st      <= S_RW;
        end
        S_RW: if (mem_rvalid) begin
          data_q <= step_d(data_q);
          if (last) begin
            addr_sv <= addr_q;
            data_sv <= step_d(data_q);
            len_q   <= {len_q[6:0], ^(len_q & LEN_TAPS)};
            run_cnt <= run_cnt + 1'b1;
            cnt     <= '0;
            st      <= S_WR;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= S_RD;
          end
        end
        default: st <= S_WR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt        <= '0;
      fail           <= 1'b0;
      first_err_addr <= '0;
    end else if (bad) begin
      if (err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
      if (!fail) first_err_addr <= rd_addr;
      fail <= 1'b1;
    end
  end

endmodule

// File: rtl/memport_tester_chk.sv
module memport_tester_chk #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int ERR_W = 4,
  parameter int RUN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_ack,
  input logic             fail,
  input logic [ERR_W-1:0] err_cnt,
  input logic [AW-1:0]    first_err_addr,
  input logic [RUN_W-1:0] run_cnt
);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  p_addr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr != '0);

  p_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> !mem_req);

  p_err_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt != $past(err_cnt) |-> err_cnt == ERR_W'($past(err_cnt) + 1'b1));

  p_err_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_cnt) |=> (&err_cnt));

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail && $stable(first_err_addr));

  p_fail_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail == (err_cnt != '0));

  p_run_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt != $past(run_cnt) |-> run_cnt == RUN_W'($past(run_cnt) + 1'b1) && mem_req && mem_we);

endmodule

bind memport_tester memport_tester_chk #(.AW(AW), .DW(DW), .ERR_W(ERR_W), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .fail(fail), .err_cnt(err_cnt),
  .first_err_addr(first_err_addr), .run_cnt(run_cnt)
);

// File: tb/test_memport_tester.sv
module test_memport_tester;
  localparam int AW = 10, DW = 16, ERR_W = 4, RUN_W = 16;

  logic clk = 0, rst_n = 0;
  logic mem_req, mem_we, mem_ack, mem_rvalid, fail;
  logic [AW-1:0] mem_addr, first_err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [ERR_W-1:0] err_cnt;
  logic [RUN_W-1:0] run_cnt;

  always #4 clk = ~clk;

  memport_tester i_memport_tester (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .fail(fail), .err_cnt(err_cnt), .first_err_addr(first_err_addr), .run_cnt(run_cnt));

  int checks = 0, failures = 0;
  int cyc = 0;
  int corrupt_n = 0;
  bit corrupt_rec = 0;
  logic [AW-1:0] corrupt_addr = '0;
  logic [DW-1:0] mem [1024];

  function automatic logic [AW-1:0] f_a(input logic [AW-1:0] s);
    return {s[AW-2:0], s[9] ^ s[6]};
  endfunction
  function automatic logic [DW-1:0] f_d(input logic [DW-1:0] s);
    return {s[DW-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction
  function automatic logic [7:0] f_l(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model with random acknowledge latency and optional read corruption
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_rvalid <= 0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 0;
      if (mem_req && mem_ack) begin
        mem_ack <= 0;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else begin
          mem_rvalid <= 1;
          if (corrupt_n > 0) begin
            mem_rdata <= mem[mem_addr] ^ 16'h0001;
            corrupt_n = corrupt_n - 1;
            if (!corrupt_rec) begin corrupt_rec = 1; corrupt_addr = mem_addr; end
          end else mem_rdata <= mem[mem_addr];
        end
      end else mem_ack <= mem_req && ($urandom_range(0, 2) == 0);
    end
  end

  // stream tracker: expected sequences computed from the generator definitions
  logic [AW-1:0] b_a;
  logic [DW-1:0] b_d;
  logic [7:0] b_len;
  logic [AW-1:0] rq [16];
  int wr_n, rd_n, b_runs;

  always @(negedge clk) begin
    if (!rst_n) begin
      b_a = 10'h001; b_d = 16'hACE1; b_len = 8'h5A; wr_n = 0; rd_n = 0; b_runs = 0;
    end else if (mem_req && mem_ack) begin
      if (mem_we) begin
        if (wr_n == 0) check(run_cnt == RUN_W'(b_runs), "R9", "run count at run start", run_cnt, b_runs);
        check(mem_addr == b_a, "R2", "write address", mem_addr, b_a);
        check(mem_wdata == b_d, "R3", "write data", mem_wdata, b_d);
        check(wr_n < int'(b_len[3:0]) + 1, "R4", "writes in run", wr_n + 1, int'(b_len[3:0]) + 1);
        if (wr_n < 16) rq[wr_n] = mem_addr;
        wr_n++;
        b_a = f_a(b_a); b_d = f_d(b_d);
      end else begin
        if (rd_n == 0) check(wr_n == int'(b_len[3:0]) + 1, "R4", "run length", wr_n, int'(b_len[3:0]) + 1);
        check(mem_addr == rq[rd_n[3:0]], "R6", "readback address order", mem_addr, rq[rd_n[3:0]]);
        rd_n++;
        if (rd_n == int'(b_len[3:0]) + 1) begin
          b_runs++; b_len = f_l(b_len); wr_n = 0; rd_n = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "WD", "watchdog expired", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_runs(input int n);
    int tgt = int'(run_cnt) + n;
    while (int'(run_cnt) < tgt) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(mem_req && mem_we, "R1", "write phase in reset", {mem_req, mem_we}, 2'b11);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    foreach (mem[i]) mem[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state, sampled before the first clock edge after release
    check(mem_req && mem_we, "R1", "write phase", {mem_req, mem_we}, 2'b11);
    check(mem_addr == 10'h001, "R1", "first address", mem_addr, 10'h001);
    check(mem_wdata == 16'hACE1, "R1", "first data", mem_wdata, 16'hACE1);
    check(err_cnt == 0 && !fail, "R1", "error state", {fail, err_cnt}, 0);
    check(run_cnt == 0 && first_err_addr == 0, "R1", "run count and first address", run_cnt, 0);

    // clean traffic
    wait_runs(25);
    check(!fail, "R7", "no fail on clean runs", fail, 0);
    check(err_cnt == 0, "R7", "no errors on clean runs", err_cnt, 0);
    check(run_cnt == 25, "R9", "runs completed", run_cnt, 25);

    // single corrupted word
    while (!(mem_req && !mem_we)) @(negedge clk);
    corrupt_n = 1;
    wait_runs(2);
    check(err_cnt == 1, "R7", "single mismatch counted", err_cnt, 1);
    check(fail, "R8", "fail raised", fail, 1);
    check(first_err_addr == corrupt_addr, "R8", "first failing address", first_err_addr, corrupt_addr);

    // many corrupted words: saturation and sticky first address
    corrupt_n = 20;
    while (corrupt_n > 0) @(negedge clk);
    wait_runs(2);
    check(err_cnt == 4'hF, "R7", "error count saturates", err_cnt, 4'hF);
    check(fail, "R8", "fail stays high", fail, 1);
    check(first_err_addr == corrupt_addr, "R8", "first address held", first_err_addr, corrupt_addr);

    // reset mid-run restarts the sequence cleanly
    do_reset();
    check(err_cnt == 0 && !fail && run_cnt <= 1, "R1", "cleared by reset", {fail, err_cnt}, 0);
    wait_runs(5);
    check(!fail && err_cnt == 0, "R7", "clean after reset", err_cnt, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule